// File: doc/BRIEF.md
# System Reset Request Port

This block is a one-byte I/O register through which software asks the platform for a system reset. It sits on a simple byte-wide I/O bus with separate read and write strobes, answers only at I/O address 0xCF9, and drives a reset-request line toward the platform's reset sequencer. The sequencer itself, and the meaning of the retained reset-type flag, are outside this block.

A write whose data has bit 2 set is a trigger. It raises the reset request for one clock and leaves the stored flag untouched. Any other write to the register keeps only data bit 1, the reset-type flag. A read of the register returns that flag in bit 1, with every other bit zero. When the register is not being read, the read bus is zero, so it can be ORed with other sources.

Top module: `rst_req_port`

## Requirements
- R1: The register responds only when the I/O address equals 0xCF9; reads of any other address return 0x00.
- R2: A write to 0xCF9 with data bit 2 = 1 drives `sys_rst_req` high in the clock cycle that follows the write edge. The output stays high for exactly one cycle for each write cycle.
- R3: A trigger write (data bit 2 = 1) leaves the stored flag unchanged, as seen by a later read.
- R4: A write to 0xCF9 with data bit 2 = 0 stores data bit 1 only; read data bits 7..2 and bit 0 are always zero.
- R5: A read of 0xCF9 returns the stored flag in bit 1 in the same cycle as the read strobe.
- R6: `io_rdata` is 0x00 whenever `io_rd` is low.
- R7: While `rst_n` is low, and directly after it is released, the stored flag is zero and `sys_rst_req` is low.
- R8: Writes to any address other than 0xCF9 change neither the stored flag nor `sys_rst_req`, whatever their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one per clock cycle held |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| sys_rst_req | output | 1 | Reset request pulse to the reset sequencer |

## Verification
The only state is a single flag plus the pulse register. A wrong flag shows up on the very next read of 0xCF9. A wrong pulse register shows up on `sys_rst_req` one clock after the offending write. The test drives each class of write: trigger, plain, foreign address, and trigger with bit 1 set. Each is followed at once by a read-back, so that any corruption shows within two cycles.

// File: rtl/rst_req_pkg.sv
package rst_req_pkg;
  localparam int unsigned IO_ADDR_W   = 16;
  localparam int unsigned IO_DATA_W   = 8;
  localparam logic [IO_ADDR_W-1:0] PORT_ADDR = 16'hCF9;
  localparam int unsigned TRIG_POS    = 2;
  localparam int unsigned TYPE_POS    = 1;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_TRIG  = 2'b10
  } acc_kind_e;
endpackage

// File: rtl/rst_req_decode.sv
module rst_req_decode
  import rst_req_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned DATA_W = IO_DATA_W,
  parameter logic [ADDR_W-1:0] MATCH = PORT_ADDR[ADDR_W-1:0],
  parameter int unsigned TRIG_BIT = TRIG_POS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_hit,
  output acc_kind_e         wr_kind
);
  logic hit;

  always_comb begin
    hit    = (addr == MATCH);
    rd_hit = hit && rd;
    if (hit && wr) begin
      wr_kind = wdata[TRIG_BIT] ? ACC_TRIG : ACC_STORE;
    end else begin
      wr_kind = ACC_NONE;
    end
  end
endmodule

// File: rtl/rst_req_flag.sv
module rst_req_flag
  import rst_req_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e wr_kind,
  input  logic      type_in,
  output logic      flag_q
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = (wr_kind == ACC_STORE);
    flag_d  = type_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/rst_req_pulse.sv
module rst_req_pulse
  import rst_req_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e wr_kind,
  output logic      req_q
);
  logic req_d;

  always_comb begin
    req_d = (wr_kind == ACC_TRIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/rst_req_port.sv
module rst_req_port
  import rst_req_pkg::*;
#(
  parameter int unsigned ADDR_W = IO_ADDR_W,
  parameter int unsigned DATA_W = IO_DATA_W,
  parameter logic [ADDR_W-1:0] MATCH = PORT_ADDR[ADDR_W-1:0],
  parameter int unsigned TRIG_BIT = TRIG_POS,
  parameter int unsigned TYPE_BIT = TYPE_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sys_rst_req
);
  localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

  logic      rd_hit;
  acc_kind_e wr_kind;
  logic      flag_q;

  rst_req_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH(MATCH), .TRIG_BIT(TRIG_BIT)
  ) u_decode (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .wdata(io_wdata),
    .rd_hit(rd_hit), .wr_kind(wr_kind)
  );

  rst_req_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind),
    .type_in(io_wdata[TYPE_BIT]), .flag_q(flag_q)
  );

  rst_req_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .req_q(sys_rst_req)
  );

  always_comb begin
    io_rdata = rd_hit ? (flag_q ? TYPE_MASK : '0) : '0;
  end
endmodule

// File: rtl/rst_req_port_chk.sv
module rst_req_port_chk
  import rst_req_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        sys_rst_req,
  input logic        flag_q
);
  logic trig_wr, store_wr, foreign_wr;
  assign trig_wr    = io_wr && (io_addr == PORT_ADDR) && io_wdata[TRIG_POS];
  assign store_wr   = io_wr && (io_addr == PORT_ADDR) && !io_wdata[TRIG_POS];
  assign foreign_wr = io_wr && (io_addr != PORT_ADDR);

  assert_trig_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> sys_rst_req);

  assert_pulse_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(trig_wr));

  assert_trig_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> $stable(flag_q));

  assert_store_takes_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |=> (flag_q == $past(io_wdata[TYPE_POS])));

  assert_other_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata & ~(8'h01 << TYPE_POS)) == 8'h00);

  assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

  assert_foreign_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_wr && !store_wr |=> $stable(flag_q));
endmodule

bind rst_req_port rst_req_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .sys_rst_req(sys_rst_req),
  .flag_q(flag_q)
);

// File: tb/tb_rst_req_port.sv
`timescale 1ns/1ps
module tb_rst_req_port;
  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        sys_rst_req;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  rst_req_port dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Write one cycle; returns req seen right after the capturing edge and one cycle later.
  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          output logic req0, output logic req1);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = 8'h00;
    req0 = sys_rst_req;
    @(negedge clk);
    req1 = sys_rst_req;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check8("R7 req in reset", {7'b0, sys_rst_req}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    do_read(16'hCF9, d);
    check8("R7 flag after reset", d, 8'h00);
    check8("R7 req after reset", {7'b0, sys_rst_req}, 8'h00);
  endtask

  task automatic t_store;
    logic r0, r1; logic [7:0] d;
    do_write(16'hCF9, 8'hFB, r0, r1);  // bit2=0, bit1=1, others set
    do_read(16'hCF9, d);
    check8("R4 store bit1 only", d, 8'h02);
    check8("R5 read value", d, 8'h02);
    check8("R4 no pulse on store", {6'b0, r0, r1}, 8'h00);
    do_write(16'hCF9, 8'hF9, r0, r1);  // bit1=0
    do_read(16'hCF9, d);
    check8("R4 store clears", d, 8'h00);
  endtask

  task automatic t_trigger;
    logic r0, r1; logic [7:0] d;
    do_write(16'hCF9, 8'h02, r0, r1);
    do_write(16'hCF9, 8'h04, r0, r1);  // trigger with bit1=0
    check8("R2 pulse high one cycle", {6'b0, r0, r1}, 8'h02);
    do_read(16'hCF9, d);
    check8("R3 trigger keeps flag=1", d, 8'h02);
    do_write(16'hCF9, 8'h00, r0, r1);
    do_write(16'hCF9, 8'h06, r0, r1);  // trigger with bit1=1
    check8("R2 pulse again", {6'b0, r0, r1}, 8'h02);
    do_read(16'hCF9, d);
    check8("R3 trigger keeps flag=0", d, 8'h00);
  endtask

  task automatic t_foreign;
    logic r0, r1; logic [7:0] d;
    do_write(16'hCF8, 8'h06, r0, r1);
    check8("R8 no pulse CF8", {6'b0, r0, r1}, 8'h00);
    do_write(16'h0CF9 ^ 16'h1000, 8'h02, r0, r1);
    do_read(16'hCF9, d);
    check8("R8 flag untouched", d, 8'h00);
    do_write(16'hCF9, 8'h02, r0, r1);
    do_read(16'hCFA, d);
    check8("R1 other address reads zero", d, 8'h00);
    do_read(16'hCF9, d);
    check8("R1 decode hit", d, 8'h02);
  endtask

  task automatic t_idle;
    @(negedge clk);
    io_addr = 16'hCF9; io_rd = 1'b0;
    #1;
    check8("R6 idle bus zero", io_rdata, 8'h00);
  endtask

  initial begin
    io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_trigger();
    t_foreign();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule